// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether a received Ethernet frame should be kept by looking only at its 48-bit destination address. A host programs it through a small 32-bit register bus: a mode register picks which address classes are accepted outright, an enable register switches individual table entries on or off, and a table of up to sixteen stored station addresses supplies exact-match candidates.

The receive path presents each destination address with a one-cycle strobe. One clock later the block returns a result strobe together with an accept flag and a code naming the rule that let the frame through. A table hit only counts while table comparison is enabled in the mode register. A frame that no enabled rule covers is rejected with the code for "none". Promiscuous reception is obtained by setting every mode bit. Ordinary station reception sets only the table-compare and broadcast bits.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset the mode register, the entry-enable register and every table word read back as zero, and every presented address is rejected with source code 0.
- R2: The mode register is at offset 0x00. Bit 0 accepts every unicast address, bit 1 accepts every non-broadcast multicast address, bit 2 accepts the broadcast address, and bit 4 enables table comparison. All other bits are ignored on write and read back as zero.
- R3: The entry-enable register is at offset 0x04. Bit n enables table entry n, and bits at or above the entry count read back as zero.
- R4: Entry n has its first word at offset 0x08+8n and its second word at 0x0C+8n. Address byte 0 (the first byte on the wire, carried on da[47:40]) sits in bits 31:24 of the first word, and bytes 1 to 3 follow downward. Bytes 4 and 5 sit in bits 31:16 of the second word. The low 16 bits of the second word are ignored on write and read as zero.
- R5: An address is broadcast when all 48 bits are one. It is multicast when da[40] (bit 0 of byte 0) is one and it is not broadcast. It is unicast when da[40] is zero.
- R6: A table hit needs the compare bit, the entry's enable bit, and all 48 bits equal to the stored address. A disabled entry never produces a match.
- R7: The unicast-all bit accepts only unicast addresses. The multicast-all bit accepts only multicast, non-broadcast addresses. The broadcast bit accepts only the broadcast address.
- R8: res_valid is high exactly in the cycle after a da_valid cycle. In that cycle res_accept is one exactly when res_src is non-zero. res_src codes: 0 none, 1 table, 2 unicast-all, 3 multicast-all, 4 broadcast. When res_valid is low, both res_accept and res_src are zero.
- R9: When several rules match, res_src reports the first of: table, broadcast, multicast-all, unicast-all.
- R10: When a register write and an address strobe fall in the same cycle, the decision uses the configuration from before that write. The write takes effect for later strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 on bits 47:40 |
| res_valid | output | 1 | Decision strobe, one cycle after da_valid |
| res_accept | output | 1 | Frame accepted |
| res_src | output | 3 | Matching rule code |

## Verification
A register write from the host and an address strobe from the receive path can land in the same clock cycle. The bench provokes this by rewriting a matching table entry, or clearing the mode register, in the very cycle the matching address is strobed. It expects the old configuration to decide that frame, and the new configuration to decide the next strobe of the same address. Expected codes come from a shadow model of the programmed state kept inside the bench.

// File: rtl/rxaf_pkg.sv
// Shared types for the receive address filter.
// Assumes match-source codes are consumed by neighbours as fixed values.
package rxaf_pkg;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_TABLE = 3'd1,
        SRC_UCAST = 3'd2,
        SRC_MCAST = 3'd3,
        SRC_BCAST = 3'd4
    } rxaf_src_e;

    typedef struct packed {
        logic cmp_en;
        logic bc_all;
        logic mc_all;
        logic uc_all;
    } rxaf_mode_t;

endpackage

// File: rtl/rxaf_regs.sv
// Register file: mode bits, per-entry enables and address table.
// Assumes N_ENTRY <= 32 and that ADDR_W covers offset 0x0C+8*(N_ENTRY-1).
// Reads are combinational; writes land at the clock edge.
module rxaf_regs
    import rxaf_pkg::*;
#(
    parameter int N_ENTRY = 16,
    parameter int ADDR_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output rxaf_mode_t              mode,
    output logic [N_ENTRY-1:0]      ent_en,
    output logic [N_ENTRY-1:0][47:0] tbl
);
    localparam int IDX_W = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1;
    localparam int OFS_W = ADDR_W - 3;

    logic [ADDR_W-1:0] off;
    logic              tbl_sel;
    logic              hi_word;
    logic [IDX_W-1:0]  ent_idx;

    // Decode the table window: entry stride 8 bytes, starting at 0x08.
    always_comb begin
        off     = reg_addr - ADDR_W'(8);
        ent_idx = off[3 +: IDX_W];
        hi_word = (off[2] == 1'b0);
        tbl_sel = (reg_addr >= ADDR_W'(8)) && (off[1:0] == 2'b00) &&
                  (32'(off[ADDR_W-1:3]) < 32'(N_ENTRY));
    end

    // Store mode, enables and table words on host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= '0;
            ent_en <= '0;
            tbl    <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(0)) begin
                mode.uc_all <= reg_wdata[0];
                mode.mc_all <= reg_wdata[1];
                mode.bc_all <= reg_wdata[2];
                mode.cmp_en <= reg_wdata[4];
            end else if (reg_addr == ADDR_W'(4)) begin
                ent_en <= reg_wdata[N_ENTRY-1:0];
            end else if (tbl_sel) begin
                if (hi_word) tbl[ent_idx][47:16] <= reg_wdata[31:0];
                else         tbl[ent_idx][15:0]  <= reg_wdata[31:16];
            end
        end
    end

    // Return the addressed register, zero for unmapped offsets.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(0)) begin
            reg_rdata = {27'd0, mode.cmp_en, 1'b0, mode.bc_all, mode.mc_all, mode.uc_all};
        end else if (reg_addr == ADDR_W'(4)) begin
            reg_rdata[N_ENTRY-1:0] = ent_en;
        end else if (tbl_sel) begin
            if (hi_word) reg_rdata = tbl[ent_idx][47:16];
            else         reg_rdata = {tbl[ent_idx][15:0], 16'd0};
        end
    end

    initial begin
        assert (OFS_W >= IDX_W) else $error("address width too small for table");
    end

endmodule

// File: rtl/rxaf_cam.sv
// Parallel exact-match compare of one address against every table entry.
// Assumes the table and enables are stable registers; output is combinational.
module rxaf_cam #(
    parameter int N_ENTRY = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [47:0]              da,
    input  logic [N_ENTRY-1:0]       ent_en,
    input  logic [N_ENTRY-1:0][47:0] tbl,
    output logic                     any_hit
);
    logic [N_ENTRY-1:0] hit_vec;

    // One comparator per entry, gated by that entry's enable.
    for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
        assign hit_vec[g] = ent_en[g] && (tbl[g] == da);
    end

    // Reduce the per-entry hits to a single flag.
    assign any_hit = |hit_vec;

    AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (ent_en != '0)) else $error("hit with no enabled entry"); // R6

endmodule

// File: rtl/rxaf_decide.sv
// Classifies the address, applies the mode rules in priority order and
// registers the result one cycle after the strobe.
// Assumes any_hit is the combinational table result for the same address.
module rxaf_decide
    import rxaf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       da_valid,
    input  logic [47:0] da,
    input  rxaf_mode_t mode,
    input  logic       any_hit,
    output logic       res_valid,
    output logic       res_accept,
    output logic [2:0] res_src
);
    logic      is_bc, is_mc, is_uc;
    logic      r_tbl, r_bc, r_mc, r_uc;
    rxaf_src_e src_n;

    // Classify the address and evaluate each rule separately.
    always_comb begin
        is_bc = &da;
        is_mc = da[40] && !is_bc;
        is_uc = !da[40];
        r_tbl = mode.cmp_en && any_hit;
        r_bc  = mode.bc_all && is_bc;
        r_mc  = mode.mc_all && is_mc;
        r_uc  = mode.uc_all && is_uc;
    end

    // Pick the reporting rule: table, broadcast, multicast, unicast.
    always_comb begin
        if (r_tbl)     src_n = SRC_TABLE;
        else if (r_bc) src_n = SRC_BCAST;
        else if (r_mc) src_n = SRC_MCAST;
        else if (r_uc) src_n = SRC_UCAST;
        else           src_n = SRC_NONE;
    end

    // Register the decision; outputs are zero outside the result cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_src    <= 3'd0;
        end else begin
            res_valid  <= da_valid;
            res_accept <= da_valid && (r_tbl || r_bc || r_mc || r_uc);
            res_src    <= da_valid ? src_n : 3'd0;
        end
    end

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> res_valid) else $error("missing result"); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> !res_valid) else $error("spurious result"); // R8
    AST_ACCEPT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_accept == (res_src != 3'd0))) else $error("accept/code mismatch"); // R8
    AST_BCAST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_src == 3'd4) |-> $past(&da)) else $error("bcast code on other address"); // R7
    AST_MCAST_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_src == 3'd3) |-> ($past(da[40]) && !$past(&da))) else $error("mcast code misclassified"); // R5
    AST_UCAST_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_src == 3'd2) |-> !$past(da[40])) else $error("ucast code on group address"); // R7
    AST_TABLE_NEEDS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_src == 3'd1) |-> $past(mode.cmp_en)) else $error("table hit while compare off"); // R6

endmodule

// File: rtl/eth_rx_addr_filter.sv
// Top of the receive destination-address filter: register file, table
// comparator and decision stage. Assumes a single clock domain and that
// da is held only in the strobe cycle.
module eth_rx_addr_filter
    import rxaf_pkg::*;
#(
    parameter int N_ENTRY = 16,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              da_valid,
    input  logic [47:0]       da,
    output logic              res_valid,
    output logic              res_accept,
    output logic [2:0]        res_src
);
    rxaf_mode_t                mode;
    logic [N_ENTRY-1:0]        ent_en;
    logic [N_ENTRY-1:0][47:0]  tbl;
    logic                      any_hit;

    rxaf_regs #(.N_ENTRY(N_ENTRY), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mode(mode), .ent_en(ent_en), .tbl(tbl)
    );

    rxaf_cam #(.N_ENTRY(N_ENTRY)) u_cam (
        .clk(clk), .rst_n(rst_n), .da(da), .ent_en(ent_en), .tbl(tbl),
        .any_hit(any_hit)
    );

    rxaf_decide u_dec (
        .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
        .mode(mode), .any_hit(any_hit),
        .res_valid(res_valid), .res_accept(res_accept), .res_src(res_src)
    );

endmodule

// File: tb/sim_eth_rx_addr_filter.sv
// Directed bench for the receive address filter with a shadow model.
module sim_eth_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        res_valid, res_accept;
    logic [2:0]  res_src;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // shadow of the programmed configuration
    logic [4:0]  s_mode = '0;
    logic [15:0] s_en = '0;
    logic [47:0] s_tbl [16];

    localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] UA  = 48'h0002_AC55_88A8;
    localparam logic [47:0] UB  = 48'h0A1B_2C3D_4E5F;
    localparam logic [47:0] MA  = 48'h0100_5E00_00FB;

    always #4 clk = ~clk;

    eth_rx_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .da_valid(da_valid),
        .da(da), .res_valid(res_valid), .res_accept(res_accept), .res_src(res_src)
    );

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] model(input logic [47:0] a);
        logic hit = 1'b0;
        for (int i = 0; i < 16; i++) if (s_en[i] && s_tbl[i] == a) hit = 1'b1;
        if (s_mode[4] && hit)                 return 3'd1;
        if (s_mode[2] && a == BC)             return 3'd4;
        if (s_mode[1] && a[40] && a != BC)    return 3'd3;
        if (s_mode[0] && !a[40])              return 3'd2;
        return 3'd0;
    endfunction

    function automatic void shadow_wr(input logic [7:0] a, input logic [31:0] d);
        if (a == 8'h00) s_mode = {d[4], 1'b0, d[2:0]};
        else if (a == 8'h04) s_en = d[15:0];
        else if (a >= 8'h08 && a <= 8'h84 && a[1:0] == 2'b00) begin
            if (a[2] == 1'b0) s_tbl[(a - 8'h08) >> 3][47:16] = d;
            else              s_tbl[(a - 8'h08) >> 3][15:0]  = d[31:16];
        end
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        shadow_wr(a, d);
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 chk(tag, 48'(reg_rdata), 48'(exp));
    endtask

    task automatic set_entry(input int n, input logic [47:0] a);
        wr(8'(8 + 8 * n), a[47:16]);
        wr(8'(12 + 8 * n), {a[15:0], 16'h0});
    endtask

    task automatic probe(input string tag, input logic [47:0] a);
        logic [2:0] e;
        @(negedge clk);
        da_valid = 1'b1; da = a; e = model(a);
        @(negedge clk);
        da_valid = 1'b0; da = '0;
        chk({tag, " R8 valid"}, 48'(res_valid), 48'd1);
        chk({tag, " src"}, 48'(res_src), 48'(e));
        chk({tag, " R8 accept"}, 48'(res_accept), 48'(e != 3'd0));
        @(negedge clk);
        chk({tag, " R8 single"}, 48'({res_valid, res_accept, res_src}), 48'd0);
    endtask

    task automatic t_reset();
        rd("R1 mode", 8'h00, 32'h0);
        rd("R1 enable", 8'h04, 32'h0);
        rd("R1 tbl hi", 8'h08, 32'h0);
        rd("R1 tbl lo", 8'h84, 32'h0);
        chk("R1 idle", 48'({res_valid, res_accept, res_src}), 48'd0);
        probe("R1 bcast", BC);
        probe("R1 ucast", UA);
    endtask

    task automatic t_regmap();
        wr(8'h00, 32'hFFFF_FFFF);
        rd("R2 mode bits", 8'h00, 32'h0000_0017);
        wr(8'h04, 32'hFFFF_FFFF);
        rd("R3 enable width", 8'h04, 32'h0000_FFFF);
        set_entry(15, 48'h1122_3344_5566);
        rd("R4 first word", 8'h80, 32'h1122_3344);
        rd("R4 second word", 8'h84, 32'h5566_0000);
        wr(8'h84, 32'hABCD_1234);
        rd("R4 low half ignored", 8'h84, 32'hABCD_0000);
        wr(8'h00, 32'h0); wr(8'h04, 32'h0);
    endtask

    task automatic t_table();
        set_entry(0, UA);
        set_entry(5, MA);
        set_entry(9, UB);
        wr(8'h04, 32'h0000_0021);
        probe("R6 compare off", UA);
        wr(8'h00, 32'h0000_0010);
        probe("R6 entry0 hit", UA);
        probe("R6 entry5 mcast hit", MA);
        probe("R6 entry9 disabled", UB);
        probe("R6 one bit off", UA ^ 48'h1);
        probe("R6 bcast not in table", BC);
    endtask

    task automatic t_classes();
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h0000_0001);
        probe("R7 uc-all ucast", UB);
        probe("R7 uc-all mcast", MA);
        probe("R7 uc-all bcast", BC);
        wr(8'h00, 32'h0000_0002);
        probe("R5 mc-all mcast", MA);
        probe("R5 mc-all bcast excluded", BC);
        probe("R7 mc-all ucast", UB);
        wr(8'h00, 32'h0000_0004);
        probe("R7 bc bcast", BC);
        probe("R7 bc mcast", MA);
        probe("R5 near-bcast", BC ^ 48'h1);
    endtask

    task automatic t_priority();
        set_entry(3, BC);
        wr(8'h04, 32'h0000_0009);
        wr(8'h00, 32'h0000_0017);
        probe("R9 table over bcast", BC);
        probe("R9 table over ucast", UA);
        probe("R9 mcast over nothing", MA);
        probe("R9 ucast fallback", UB);
        wr(8'h04, 32'h0);
        probe("R9 bcast after table off", BC);
    endtask

    task automatic t_same_cycle();
        logic [2:0] e;
        wr(8'h00, 32'h0000_0010);
        set_entry(0, UA);
        wr(8'h04, 32'h0000_0001);
        // rewrite entry 0 while its address is strobed
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h7777_7777;
        da_valid = 1'b1; da = UA; e = model(UA);
        @(negedge clk);
        reg_wr = 1'b0; da_valid = 1'b0;
        shadow_wr(8'h08, 32'h7777_7777);
        chk("R10 old entry used", 48'(res_src), 48'(e));
        chk("R10 old entry accept", 48'(res_accept), 48'd1);
        probe("R10 new entry used", UA);
        // clear mode in the strobe cycle of a broadcast
        wr(8'h00, 32'h0000_0004);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h0;
        da_valid = 1'b1; da = BC; e = model(BC);
        @(negedge clk);
        reg_wr = 1'b0; da_valid = 1'b0;
        shadow_wr(8'h00, 32'h0);
        chk("R10 old mode used", 48'(res_src), 48'(e));
        probe("R10 new mode used", BC);
    endtask

    task automatic t_back_to_back();
        wr(8'h00, 32'h0000_0007);
        @(negedge clk);
        da_valid = 1'b1; da = UB;
        @(negedge clk);
        chk("R8 b2b first", 48'(res_src), 48'd2);
        da = MA;
        @(negedge clk);
        da_valid = 1'b0;
        chk("R8 b2b second", 48'(res_src), 48'd3);
        chk("R8 b2b valid", 48'(res_valid), 48'd1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) s_tbl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_table();
        t_classes();
        t_priority();
        t_same_cycle();
        t_back_to_back();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule